// File: doc/BRIEF.md
# Pulse-Inhibit Calibrated Timebase Divider

This block turns a 32768 Hz crystal clock into the seconds and minutes time base of a watch. The oscillator is built to run slightly fast, never slow. A first stage divides the input by four into an 8192 Hz pulse stream, and a 6-bit calibration value `n` then throws away `n` pulses of that stream in every minute. Each step of `n` takes out about 2.03 ppm, which is one pulse in 8192 × 60. The surviving pulses are counted into a 1 Hz tick and a once-per-minute strobe.

The suppressed pulses are always the first `n` of each minute, so the first second of a minute is stretched by `4n` input cycles and the other seconds are exact. The calibration input is sampled only at reset and at each minute boundary, so a new value never splits a minute. A check output lets a tester read `n` back by timing alone. When the check flag is high at a tick, a pulse starts whose length is `256 + n` periods of the 8192 Hz stream, from 31.25 ms at `n = 0` up to about 38.94 ms at `n = 63`.

All division ratios are parameters, so a verification build can shrink the second and the minute.

Top module: `ptb_timebase`

## Requirements
- R1: A synchronous reset clears the prescaler, the suppression counter and the second and minute counters, and sets `tick_1hz`, `minute_strobe` and `test_pulse` low. After reset, no tick appears before the first full second has passed. The calibration value present during reset is the one used for the first minute.
- R2: The prescaler issues one 8192 Hz pulse every PRE_DIV (4) input cycles. With `n = 0`, consecutive ticks are exactly PRE_DIV × PULSES_PER_SEC (32768) input cycles apart.
- R3: The first `n` prescaler pulses after reset, and after every minute boundary, are suppressed. The first second of each minute therefore lasts PRE_DIV × (PULSES_PER_SEC + n) cycles, and every other second lasts PRE_DIV × PULSES_PER_SEC cycles. Pulses are only ever removed, never added.
- R4: `minute_strobe` is high in the same cycle as the tick that ends the last second of a minute. One minute spans PRE_DIV × (PULSES_PER_SEC × SECS_PER_MIN + n) cycles.
- R5: `cal_n` is sampled only while reset is held and at the input clock edge that closes a minute. Changes at any other time have no effect on tick timing until the next minute.
- R6: If `check_mode` is high at the edge that produces a tick, `test_pulse` goes high in the same cycle as that tick. It stays high for PRE_DIV × (TEST_BASE + n) cycles, where `n` is the value in force for the second that begins at that tick. TEST_BASE defaults to 256.
- R7: If `check_mode` is low at a tick, no test pulse starts. A pulse that is already running always runs to its full length.
- R8: `tick_1hz` and `minute_strobe` are each high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz crystal clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_n | input | 6 | Number of 8192 Hz pulses to remove per minute |
| check_mode | input | 1 | Enables the calibration read-back pulse |
| tick_1hz | output | 1 | One-cycle pulse once per corrected second |
| minute_strobe | output | 1 | One-cycle pulse at the end of each minute |
| test_pulse | output | 1 | Level whose duration encodes the active calibration value |

## Verification
The assertions assume that the parameters keep a second longer than the longest possible test pulse. If they did not, a new tick could retrigger a pulse that is still running. The bench shrinks the second to 128 pulses and the minute to two seconds, and it sets the test base to 32, so this ordering still holds for every `n` up to 63. The calibration value and the check flag change only at falling clock edges. They are drawn at random at random moments, including just before minute boundaries, and the bench's model takes the value present at the boundary edge as the one in force.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   localparam int CAL_W   = 6;
   localparam int CAL_MAX = (1 << CAL_W) - 1;
   typedef logic [CAL_W-1:0] cal_t;
endpackage

// File: rtl/ptb_prescale.sv
module ptb_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic stb
);
   localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   logic [W-1:0] cnt;

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else     cnt <= cnt + 1'b1;
         end
      end else begin : g_any
         always_ff @(posedge clk) begin
            if (rst)              cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign stb = (cnt == LAST);

   // R2
   stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb);
endmodule

// File: rtl/ptb_inhibit.sv
module ptb_inhibit
   import ptb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic stb_in,
   input  logic new_min,
   input  cal_t cal_in,
   output logic keep,
   output cal_t n_cur
);
   cal_t gone;

   always_ff @(posedge clk) begin
      if (rst || new_min) begin
         gone  <= '0;
         n_cur <= cal_in;
      end else if (stb_in && (gone < n_cur)) begin
         gone <= gone + 1'b1;
      end
   end

   assign keep = stb_in && (gone >= n_cur);

   // R3
   inh_bound_chk: assert property (@(posedge clk) disable iff (rst)
      gone <= n_cur);
endmodule

// File: rtl/ptb_secchain.sv
module ptb_secchain #(
   parameter int PPS = 8192,
   parameter int SPM = 60
) (
   input  logic clk,
   input  logic rst,
   input  logic keep,
   output logic sec_end,
   output logic boundary,
   output logic tick,
   output logic minute
);
   localparam int PW = (PPS > 2) ? $clog2(PPS) : 1;
   localparam int SW = (SPM > 2) ? $clog2(SPM) : 1;
   localparam logic [PW-1:0] PLAST = PW'(PPS - 1);
   localparam logic [SW-1:0] SLAST = SW'(SPM - 1);

   logic [PW-1:0] pcnt;
   logic [SW-1:0] scnt;

   assign sec_end  = keep && (pcnt == PLAST);
   assign boundary = sec_end && (scnt == SLAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt   <= '0;
         scnt   <= '0;
         tick   <= 1'b0;
         minute <= 1'b0;
      end else begin
         tick   <= sec_end;
         minute <= boundary;
         if (sec_end)   pcnt <= '0;
         else if (keep) pcnt <= pcnt + 1'b1;
         if (boundary)     scnt <= '0;
         else if (sec_end) scnt <= scnt + 1'b1;
      end
   end

   // R4
   min_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
      minute |-> tick);
   // R8
   tick_single_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
endmodule

// File: rtl/ptb_testpulse.sv
module ptb_testpulse
   import ptb_pkg::*;
#(
   parameter int BASE = 256
) (
   input  logic clk,
   input  logic rst,
   input  logic stb,
   input  logic start,
   input  logic check_en,
   input  cal_t n_cur,
   output logic test_out
);
   localparam int LW = $clog2(BASE + CAL_MAX + 1);

   logic [LW-1:0] tcnt;
   logic [LW-1:0] len;

   assign len = LW'(BASE) + LW'(n_cur);

   always_ff @(posedge clk) begin
      if (rst) begin
         test_out <= 1'b0;
         tcnt     <= '0;
      end else if (start && check_en) begin
         test_out <= 1'b1;
         tcnt     <= '0;
      end else if (test_out && stb) begin
         if (tcnt == len - LW'(1)) test_out <= 1'b0;
         else                      tcnt     <= tcnt + 1'b1;
      end
   end

   // R6
   test_end_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
      (test_out && !stb) |=> test_out);
   // R7
   test_start_chk: assert property (@(posedge clk) disable iff (rst)
      (!test_out && !(start && check_en)) |=> !test_out);
endmodule

// File: rtl/ptb_timebase.sv
module ptb_timebase #(
   parameter int PRE_DIV        = 4,
   parameter int PULSES_PER_SEC = 8192,
   parameter int SECS_PER_MIN   = 60,
   parameter int TEST_BASE      = 256
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [ptb_pkg::CAL_W-1:0] cal_n,
   input  logic                      check_mode,
   output logic                      tick_1hz,
   output logic                      minute_strobe,
   output logic                      test_pulse
);
   import ptb_pkg::*;

   generate
      if (PRE_DIV < 2) begin : g_bad_pre
         $error("PRE_DIV must be at least 2");
      end
      if (PULSES_PER_SEC < 2 || SECS_PER_MIN < 2) begin : g_bad_ratio
         $error("second and minute ratios must be at least 2");
      end
      if (TEST_BASE + CAL_MAX >= PULSES_PER_SEC) begin : g_bad_test
         $error("test pulse must fit inside one second");
      end
   endgenerate

   logic stb8k;
   logic keep;
   logic sec_end;
   logic boundary;
   cal_t n_cur;

   ptb_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk (clk),
      .rst (rst),
      .stb (stb8k)
   );

   ptb_inhibit u_inh (
      .clk     (clk),
      .rst     (rst),
      .stb_in  (stb8k),
      .new_min (boundary),
      .cal_in  (cal_n),
      .keep    (keep),
      .n_cur   (n_cur)
   );

   ptb_secchain #(.PPS(PULSES_PER_SEC), .SPM(SECS_PER_MIN)) u_sec (
      .clk      (clk),
      .rst      (rst),
      .keep     (keep),
      .sec_end  (sec_end),
      .boundary (boundary),
      .tick     (tick_1hz),
      .minute   (minute_strobe)
   );

   ptb_testpulse #(.BASE(TEST_BASE)) u_tp (
      .clk      (clk),
      .rst      (rst),
      .stb      (stb8k),
      .start    (sec_end),
      .check_en (check_mode),
      .n_cur    (n_cur),
      .test_out (test_pulse)
   );

   // R5
   n_lock_chk: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> $stable(n_cur));
   // R3
   keep_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
      keep |-> stb8k);
endmodule

// File: tb/test_ptb_timebase.sv
module test_ptb_timebase;
   localparam int PRE  = 4;
   localparam int PPS  = 128;
   localparam int SPM  = 2;
   localparam int BASE = 32;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] cal_n = 6'd0;
   logic       check_mode = 1'b0;
   logic       tick_1hz, minute_strobe, test_pulse;

   int checks = 0;
   int errors = 0;
   int wd = 0;

   int cyc, next_tick, sec_idx, n_m, tp_start, tp_end;
   bit prev_tick;

   always #10 clk = ~clk;

   ptb_timebase #(.PRE_DIV(PRE), .PULSES_PER_SEC(PPS),
                  .SECS_PER_MIN(SPM), .TEST_BASE(BASE)) i_ptb_timebase (
      .clk(clk), .rst(rst), .cal_n(cal_n), .check_mode(check_mode),
      .tick_1hz(tick_1hz), .minute_strobe(minute_strobe), .test_pulse(test_pulse)
   );

   task automatic chk(input bit got, input bit exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cyc, got, exp);
      end
   endtask

   function automatic int first_sec_len(input int n);
      return PRE * (PPS + n);
   endfunction

   function automatic int test_len(input int n);
      return PRE * (BASE + n);
   endfunction

   task automatic do_reset(input logic [5:0] n);
      @(negedge clk);
      rst = 1'b1;
      cal_n = n;
      repeat (3) @(negedge clk);
      cyc = 0;
      chk(tick_1hz, 1'b0, "R1 tick in reset");
      chk(minute_strobe, 1'b0, "R1 minute in reset");
      chk(test_pulse, 1'b0, "R1 test in reset");
      rst = 1'b0;
      n_m = n;
      next_tick = first_sec_len(n_m);
      sec_idx = 0;
      tp_start = 0;
      tp_end = 0;
      prev_tick = 0;
   endtask

   task automatic run(input int cycles, input bit rnd);
      for (int k = 0; k < cycles; k++) begin
         bit et, em, etp;
         @(posedge clk);
         cyc++;
         @(negedge clk);
         et = (cyc == next_tick);
         em = et && (sec_idx == SPM - 1);
         if (!et && prev_tick)      chk(tick_1hz, 1'b0, "R8 tick width");
         else if (sec_idx == 0)     chk(tick_1hz, et, "R3 first-second tick");
         else                       chk(tick_1hz, et, "R2 tick period");
         chk(minute_strobe, em, em ? "R4 minute strobe" : "R5 minute timing");
         prev_tick = et;
         if (et) begin
            if (em) begin
               n_m = cal_n;
               sec_idx = 0;
               next_tick = cyc + first_sec_len(n_m);
            end else begin
               sec_idx++;
               next_tick = cyc + PRE * PPS;
            end
            if (check_mode) begin
               tp_start = cyc;
               tp_end = cyc + test_len(n_m);
            end
         end
         etp = (cyc >= tp_start) && (cyc < tp_end);
         chk(test_pulse, etp, etp ? "R6 test pulse length" : "R7 no test pulse");
         if (rnd) begin
            if ($urandom % 150 == 0) cal_n = 6'($urandom);
            if ($urandom % 400 == 0) check_mode = ~check_mode;
         end
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      int mlen;
      void'($urandom(32'd20240607));
      // R1 and R2: n = 0, read-back on
      check_mode = 1'b1;
      do_reset(6'd0);
      mlen = PRE * PPS * SPM;
      run(3 * mlen + 20, 1'b0);
      // R3 R4 R6: largest calibration value
      cal_n = 6'd63;
      run(3 * (mlen + 4 * 63) + 20, 1'b0);
      // R7: read-back off
      check_mode = 1'b0;
      cal_n = 6'd17;
      run(2 * (mlen + 4 * 63), 1'b0);
      // R5: random changes of n and flag at arbitrary times
      check_mode = 1'b1;
      run(10 * (mlen + 4 * 63), 1'b1);
      // R1: reset in the middle of a minute with a pulse running
      do_reset(6'd40);
      check_mode = 1'b1;
      run(3 * (mlen + 4 * 63), 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule